// File: doc/BRIEF.md
# Low-Power Watch-State Wake-Up Controller

This block holds the power mode of a small microcontroller-style system. It keeps the system in one of three run modes: fast active, medium-speed active, or low-clock subactive. A sleep request moves it into a low-clock watch state. While in watch, it tests a set of level-sensitive interrupt sources. The first source that is requested, individually enabled and not globally masked ends the watch state.

Two configuration bits pick the mode to enter on wake-up. When the target is subactive, the block goes straight there. When the target is one of the active modes, it first passes through a settle state. That state lasts for an oscillator-settling time chosen by a 3-bit field, and the chip-wide clock enable stays low for all of it. A one-cycle exception-start pulse marks the first run cycle after every wake-up.

The reset pin acts asynchronously from any state and returns the block to fast active mode. Its release is synchronised to the clock. The oscillator, the clock dividers, the CPU and the interrupt vectoring are outside this block.

Top module: `wake_ctrl`

## Requirements
- R1: While `rst_n` is low, and from the moment it falls in any state (including watch and settle), `mode` reads 0, `clk_en` is 1 and `exc_start` is 0. None of these waits for a clock edge.
- R2: `mode` encodes the state as follows: 0 fast active, 1 medium active, 2 subactive, 3 watch, 4 settle. In any run mode, a high `sleep_req` at a clock edge gives `mode` 3 and `clk_en` 0 from that edge on. In watch and settle, `sleep_req` has no effect.
- R3: Source i (bits 0-2 timers, bit 3 external line, bits 4-11 wake pins) ends watch only when `irq_req[i]` and `irq_en[i]` are both 1 and `irq_mask` is 0. A source that is disabled leaves the block in watch, and so does any source while `irq_mask` is 1.
- R4: On a wake-up with `sel_sub` 1, `mode` becomes 2 at the very next edge, whatever the value of `sel_mid`, with no settle state. `exc_start` is high in that same cycle.
- R5: On a wake-up with `sel_sub` 0, the block enters settle (4). After settle it moves to mode 0 if `sel_mid` was 0 at the wake edge, or to mode 1 if it was 1. Changes to `sel_mid` or `settle_sel` during settle are ignored.
- R6: Settle lasts exactly N cycles, with `clk_en` 0 throughout. N depends on the `settle_sel` value captured at the wake edge. For values 0 to 4, N = 2^(SETTLE_LOG2 + value). Value 5 gives N = 2, value 6 gives N = 8, and value 7 gives N = 16. `clk_en` is 1 in every run mode.
- R7: `exc_start` is high for exactly one cycle: the first run-mode cycle after a wake-up. It is low at all other times.
- R8: A source that is already requested and enabled when watch is entered ends watch after a single watch cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset pin |
| irq_req | input | NSRC | Level-sensitive interrupt requests, one per source |
| irq_en | input | NSRC | Per-source enable bits |
| irq_mask | input | 1 | Global interrupt mask; 1 blocks every wake-up |
| sel_sub | input | 1 | Wake into subactive mode when 1 |
| sel_mid | input | 1 | With sel_sub 0, wake into medium active mode when 1 |
| settle_sel | input | 3 | Settle-time selection |
| sleep_req | input | 1 | Request to enter watch, honoured in run modes |
| mode | output | 3 | Current mode code |
| clk_en | output | 1 | Chip-wide clock enable, high in run modes |
| exc_start | output | 1 | One-cycle exception-start pulse after wake-up |

## Verification
The hardest situation to reach is the exit from settle. It needs a real wake-up first, and its timing depends on the captured selection and the captured target rather than on the current inputs. The bench therefore uses a small settle base. It drives every source through every settle selection with both active targets, and it counts settle cycles at the ports against the table worked out in the bench. In dedicated runs it changes `sel_mid` and `settle_sel` and holds `sleep_req` high during settle, so that capture and sleep-blocking are checked. It also pulls the reset pin in the middle of a settle.

// File: rtl/wkc_pkg.sv
package wkc_pkg;
  typedef enum logic [2:0] {
    MD_FAST   = 3'd0,
    MD_MID    = 3'd1,
    MD_SUB    = 3'd2,
    MD_WATCH  = 3'd3,
    MD_SETTLE = 3'd4
  } mode_e;
endpackage

// File: rtl/wkc_wake_gate.sv
module wkc_wake_gate #(
  parameter int NSRC = 12
) (
  input  logic [NSRC-1:0] req,
  input  logic [NSRC-1:0] en,
  input  logic            mask,
  output logic            wake
);
  logic [NSRC-1:0] qual;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign qual[g] = req[g] & en[g];
  end

  assign wake = (|qual) & ~mask;
endmodule

// File: rtl/wkc_settle_timer.sv
module wkc_settle_timer #(
  parameter int SETTLE_LOG2 = 13,
  parameter int SEL_W       = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SEL_W-1:0] sel,
  output logic             done
);
  localparam int CW = SETTLE_LOG2 + 6;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          upd;

  function automatic logic [CW-1:0] span_m1(input logic [SEL_W-1:0] s);
    logic [CW-1:0] v;
    case (s)
      SEL_W'(5): v = CW'(2);
      SEL_W'(6): v = CW'(8);
      SEL_W'(7): v = CW'(16);
      default:   v = CW'(1) << (SETTLE_LOG2 + int'(s));
    endcase
    return v - CW'(1);
  endfunction

  always_comb begin
    upd   = load | (cnt_q != '0);
    cnt_d = cnt_q;
    if (load)               cnt_d = span_m1(sel);
    else if (cnt_q != '0)   cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (upd) cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q == '0) |=> cnt_q == '0); // R6
  AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !done); // R6
endmodule

// File: rtl/wake_ctrl.sv
module wake_ctrl #(
  parameter int NSRC        = 12,
  parameter int SETTLE_LOG2 = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_req,
  input  logic [NSRC-1:0] irq_en,
  input  logic            irq_mask,
  input  logic            sel_sub,
  input  logic            sel_mid,
  input  logic [2:0]      settle_sel,
  input  logic            sleep_req,
  output logic [2:0]      mode,
  output logic            clk_en,
  output logic            exc_start
);
  import wkc_pkg::*;

  logic [1:0] rst_pipe;
  logic       rst_sn;
  mode_e      state_q, state_d;
  logic       tgt_mid_q, tgt_mid_d;
  logic       exc_d;
  logic       wake, settle_load, settle_done, run_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  wkc_wake_gate #(.NSRC(NSRC)) u_gate (
    .req  (irq_req),
    .en   (irq_en),
    .mask (irq_mask),
    .wake (wake)
  );

  wkc_settle_timer #(.SETTLE_LOG2(SETTLE_LOG2), .SEL_W(3)) u_timer (
    .clk   (clk),
    .rst_n (rst_sn),
    .load  (settle_load),
    .sel   (settle_sel),
    .done  (settle_done)
  );

  always_comb begin
    state_d     = state_q;
    tgt_mid_d   = tgt_mid_q;
    settle_load = 1'b0;
    case (state_q)
      MD_FAST, MD_MID, MD_SUB: begin
        if (sleep_req) state_d = MD_WATCH;
      end
      MD_WATCH: begin
        if (wake) begin
          if (sel_sub) begin
            state_d = MD_SUB;
          end else begin
            state_d     = MD_SETTLE;
            settle_load = 1'b1;
            tgt_mid_d   = sel_mid;
          end
        end
      end
      MD_SETTLE: begin
        if (settle_done) state_d = tgt_mid_q ? MD_MID : MD_FAST;
      end
      default: state_d = MD_FAST;
    endcase
    exc_d = ((state_q == MD_WATCH) && (state_d == MD_SUB)) ||
            ((state_q == MD_SETTLE) && (state_d != MD_SETTLE));
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q   <= MD_FAST;
      tgt_mid_q <= 1'b0;
      exc_start <= 1'b0;
    end else begin
      state_q   <= state_d;
      tgt_mid_q <= tgt_mid_d;
      exc_start <= exc_d;
    end
  end

  assign run_now = (state_q == MD_FAST) || (state_q == MD_MID) || (state_q == MD_SUB);
  assign mode    = state_q;
  assign clk_en  = run_now;

  AST_EXC_SINGLE: assert property (@(posedge clk) disable iff (!rst_sn)
    exc_start |=> !exc_start); // R7
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_sn)
    (state_q == MD_WATCH && irq_mask) |=> state_q == MD_WATCH); // R3
  AST_SUB_PULSE: assert property (@(posedge clk) disable iff (!rst_sn)
    (state_q == MD_SUB && $past(state_q) == MD_WATCH) |-> exc_start); // R4
  AST_SETTLE_EXIT: assert property (@(posedge clk) disable iff (!rst_sn)
    ($past(state_q) == MD_SETTLE && state_q != MD_SETTLE) |->
      ((state_q == MD_FAST || state_q == MD_MID) && exc_start)); // R6
endmodule

// File: tb/sim_wake_ctrl.sv
module sim_wake_ctrl;
  localparam int NSRC = 12;
  localparam int BASE = 3;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NSRC-1:0] irq_req, irq_en;
  logic            irq_mask, sel_sub, sel_mid, sleep_req;
  logic [2:0]      settle_sel;
  logic [2:0]      mode;
  logic            clk_en, exc_start;
  int checks = 0;
  int errors = 0;

  wake_ctrl #(.NSRC(NSRC), .SETTLE_LOG2(BASE)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_en(irq_en),
    .irq_mask(irq_mask), .sel_sub(sel_sub), .sel_mid(sel_mid),
    .settle_sel(settle_sel), .sleep_req(sleep_req),
    .mode(mode), .clk_en(clk_en), .exc_start(exc_start)
  );

  always #4 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int span(input int s);
    if (s < 5) return 1 << (BASE + s);
    if (s == 5) return 2;
    if (s == 6) return 8;
    return 16;
  endfunction

  task automatic enter_watch();
    @(negedge clk); sleep_req = 1'b1;
    @(negedge clk); sleep_req = 1'b0;
    chk("R2 mode watch", int'(mode), 3);
    chk("R2 clk_en in watch", int'(clk_en), 0);
  endtask

  task automatic wake_sub(input int src, input logic mid);
    sel_sub = 1'b1; sel_mid = mid;
    irq_en = '1; irq_mask = 1'b0; irq_req = NSRC'(1) << src;
    @(negedge clk); irq_req = '0;
    chk("R4 mode subactive", int'(mode), 2);
    chk("R4 exc_start on entry", int'(exc_start), 1);
    chk("R6 clk_en subactive", int'(clk_en), 1);
    @(negedge clk);
    chk("R7 exc_start single", int'(exc_start), 0);
  endtask

  task automatic wake_active(input int src, input int sel, input logic mid,
                             input logic disturb);
    int n = 0;
    sel_sub = 1'b0; sel_mid = mid; settle_sel = 3'(sel);
    irq_en = '1; irq_mask = 1'b0; irq_req = NSRC'(1) << src;
    @(negedge clk); irq_req = '0;
    if (disturb) begin
      sel_mid = ~mid; settle_sel = 3'(sel ^ 3);
      sleep_req = 1'b1;
    end
    while (mode == 3'd4 && n < 400) begin
      chk("R6 clk_en low in settle", int'(clk_en), 0);
      chk("R7 no exc in settle", int'(exc_start), 0);
      n++;
      @(negedge clk);
    end
    sleep_req = 1'b0;
    chk("R6 settle length", n, span(sel));
    chk("R5 target mode", int'(mode), mid ? 1 : 0);
    chk("R7 exc_start after settle", int'(exc_start), 1);
    chk("R6 clk_en active", int'(clk_en), 1);
    @(negedge clk);
    chk("R7 exc_start single", int'(exc_start), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; irq_req = '0; irq_en = '0; irq_mask = 1'b0;
    sel_sub = 1'b0; sel_mid = 1'b0; settle_sel = 3'd0; sleep_req = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset mode", int'(mode), 0);
    chk("R1 reset clk_en", int'(clk_en), 1);
    chk("R1 reset exc_start", int'(exc_start), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Masking and disabled sources hold watch (R3); sleep_req ignored in watch (R2)
    for (int s = 0; s < NSRC; s++) begin
      enter_watch();
      irq_req = NSRC'(1) << s; irq_en = '1; irq_mask = 1'b1; sleep_req = 1'b1;
      repeat (3) @(negedge clk);
      chk("R3 masked stays watch", int'(mode), 3);
      irq_mask = 1'b0; irq_en = ~(NSRC'(1) << s); sleep_req = 1'b0;
      repeat (3) @(negedge clk);
      chk("R3 disabled stays watch", int'(mode), 3);
      wake_sub(s, s[0]);
    end

    // Sweep every source, every settle selection, both active targets
    for (int s = 0; s < NSRC; s++)
      for (int sel = 0; sel < 8; sel++)
        for (int m = 0; m < 2; m++) begin
          enter_watch();
          wake_active(s, sel, m[0], 1'b0);
        end

    // Capture at wake edge, sleep_req blocked in settle
    enter_watch();
    wake_active(5, 2, 1'b1, 1'b1);
    enter_watch();
    wake_active(9, 7, 1'b0, 1'b1);

    // Pending and enabled at entry leaves after one watch cycle (R8)
    sel_sub = 1'b1; irq_en = '1; irq_mask = 1'b0;
    @(negedge clk); irq_req = NSRC'(1) << 4; sleep_req = 1'b1;
    @(negedge clk); sleep_req = 1'b0;
    chk("R8 one watch cycle", int'(mode), 3);
    @(negedge clk); irq_req = '0;
    chk("R8 immediate exit", int'(mode), 2);
    chk("R8 exc_start", int'(exc_start), 1);

    // Asynchronous reset during settle and during watch (R1)
    enter_watch();
    sel_sub = 1'b0; settle_sel = 3'd4; irq_req = 1;
    @(negedge clk); irq_req = '0;
    repeat (5) @(negedge clk);
    chk("R1 in settle before reset", int'(mode), 4);
    #2 rst_n = 1'b0;
    #1;
    chk("R1 async reset mode", int'(mode), 0);
    chk("R1 async reset clk_en", int'(clk_en), 1);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 stays fast after reset", int'(mode), 0);
    enter_watch();
    #2 rst_n = 1'b0;
    #1;
    chk("R1 reset from watch", int'(mode), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule